// File: doc/BRIEF.md
# Integration Period Sequencer

This block paces the integrate/convert cycle of a bank of current-input ADCs that have two integrators per channel. It counts ticks of an 80 MHz timebase (12.5 ns each). At the end of every integration period it flips a conversion line, so one integrator side is digitized while the other keeps integrating. It also raises a one-cycle frame strobe that tells the readout logic a complete set of samples is ready to fetch.

A command decoder drives the block with three one-cycle strobes: start a continuous run, take one measurement, or stop. When a run starts, the block captures the programmed period count and the gain range. Both stay frozen until the run ends. The period lasts count+1 ticks, and the count is clamped to hard lower and upper limits. The first period after a start is only half filled, so it produces no frame.

Top module: `integ_seq`

## Requirements
- R1: After reset, `busy`, `adc_conv` and `frame_rdy` are 0 and `adc_range` is 0.
- R2: When idle, a `cmd_run` or `cmd_single` strobe sampled at a clock edge starts a run. `busy` is 1 from that edge, and `adc_range` takes the value of `cfg_range` at that edge. If both strobes arrive together, `cmd_run` wins.
- R3: During a run, `adc_conv` inverts every P = (effective count + 1) cycles. The first inversion occurs P edges after the start edge.
- R4: The effective count is `cfg_count` clamped to the range [`MIN_CNT`, `MAX_CNT`], captured at the start edge.
- R5: `frame_rdy` is high for exactly one cycle at every period boundary except the first boundary of a run. Each such pulse coincides with an inversion of `adc_conv`.
- R6: A single-measurement run ends at its second boundary, which carries the run's only frame strobe. `busy` falls at the same edge where `frame_rdy` rises.
- R7: A continuous run repeats periods until a stop arrives. It ends at the first boundary at or after the edge where `cmd_stop` is sampled. `busy` falls at that boundary.
- R8: While `busy` is high, changes to `cfg_count` and `cfg_range` have no effect. The period and `adc_range` stay fixed, and further start strobes are ignored.
- R9: A `cmd_stop` strobe while idle has no effect. A later run is not cut short by it.
- R10: `adc_conv` does not change while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 80 MHz timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | CNT_W | Programmed period count (period = count+1 ticks) |
| cfg_range | input | RANGE_W | Programmed gain range |
| cmd_run | input | 1 | Start continuous acquisition strobe |
| cmd_single | input | 1 | Single-measurement strobe |
| cmd_stop | input | 1 | Stop strobe |
| adc_conv | output | 1 | Conversion line, inverted at each period boundary |
| frame_rdy | output | 1 | One-cycle strobe: a frame is ready for readout |
| busy | output | 1 | High while a run is in progress |
| adc_range | output | RANGE_W | Range captured at run start |

## Verification
The result timing is counted from the edge that samples a start strobe, called edge 0:
- `busy` and `adc_range` are valid right after edge 0.
- Each `adc_conv` inversion follows edge k·P.
- The frame strobe appears after edge k·P for k of 2 or more.
- `busy` drops after the last boundary.

The bench drives every input on the falling clock edge and counts rising edges one by one. It compares all outputs at the falling edge after each rising edge against a schedule computed from P and the number of boundaries. Stop and redundant start strobes are also placed at exact edge numbers, so each expected end boundary is known in advance.

// File: rtl/integ_seq.sv
module integ_seq #(
  parameter int CNT_W   = 28,
  parameter int RANGE_W = 2,
  parameter int MIN_CNT = 13279,
  parameter int MAX_CNT = 79999999
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic [RANGE_W-1:0] cfg_range,
  input  logic               cmd_run,
  input  logic               cmd_single,
  input  logic               cmd_stop,
  output logic               adc_conv,
  output logic               frame_rdy,
  output logic               busy,
  output logic [RANGE_W-1:0] adc_range
);

  localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] tick, cnt_q, cnt_eff;
  logic single_q, stop_q, first_q;
  logic boundary, finish, start;

  assign cnt_eff  = (cfg_count < LO) ? LO : ((cfg_count > HI) ? HI : cfg_count);
  assign start    = !busy && (cmd_run || cmd_single);
  assign boundary = busy && (tick == cnt_q);
  assign finish   = boundary && (stop_q || cmd_stop || (single_q && !first_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      adc_conv  <= 1'b0;
      frame_rdy <= 1'b0;
      adc_range <= '0;
      tick      <= '0;
      cnt_q     <= LO;
      single_q  <= 1'b0;
      stop_q    <= 1'b0;
      first_q   <= 1'b0;
    end else begin
      frame_rdy <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        single_q  <= !cmd_run;
        stop_q    <= 1'b0;
        first_q   <= 1'b1;
        tick      <= '0;
        cnt_q     <= cnt_eff;
        adc_range <= cfg_range;
      end else if (busy) begin
        if (cmd_stop) stop_q <= 1'b1;
        if (boundary) begin
          tick      <= '0;
          adc_conv  <= ~adc_conv;
          first_q   <= 1'b0;
          frame_rdy <= !first_q;
          if (finish) busy <= 1'b0;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_run || cmd_single));

  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tick <= cnt_q);

  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q >= LO && cnt_q <= HI));

  // R5
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rdy |=> !frame_rdy);

  // R5
  frame_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_rdy) |-> !$stable(adc_conv));

  // R8
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_range));

  // R10
  conv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_conv) |-> $past(busy));

endmodule

// File: tb/integ_seq_tb.sv
module integ_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int MINC  = 3;
  localparam int MAXC  = 40;

  logic clk = 0, rst_n = 0;
  logic [27:0] cfg_count = '0;
  logic [1:0]  cfg_range = '0;
  logic cmd_run = 0, cmd_single = 0, cmd_stop = 0;
  logic adc_conv, frame_rdy, busy;
  logic [1:0] adc_range;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  integ_seq #(.CNT_W(28), .RANGE_W(2), .MIN_CNT(MINC), .MAX_CNT(MAXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_range(cfg_range),
    .cmd_run(cmd_run), .cmd_single(cmd_single), .cmd_stop(cmd_stop),
    .adc_conv(adc_conv), .frame_rdy(frame_rdy), .busy(busy), .adc_range(adc_range));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cont: continuous run; P: expected period; B: boundary that ends the run
  task automatic run_seq(input bit cont, input int cnt_cfg, input logic [1:0] rng,
                         input int P, input int B, input int stop_at, input int start_at,
                         input int K, input bit cfg_chg, input string req);
    logic cref;
    @(negedge clk);
    cfg_count = 28'(cnt_cfg);
    cfg_range = rng;
    cref = adc_conv;
    if (cont) cmd_run = 1; else cmd_single = 1;
    @(negedge clk);
    cmd_run = 0; cmd_single = 0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(adc_range == rng, "R2", "range latched", int'(adc_range), int'(rng));
    if (cfg_chg) begin
      cfg_count = 28'(cnt_cfg + 7);
      cfg_range = ~rng;
    end
    for (int k = 1; k <= K; k++) begin
      bit bnd, fr, bz;
      cmd_stop = (k == stop_at);
      cmd_single = (k == start_at);
      @(negedge clk);
      bnd = (k % P == 0) && (k / P <= B);
      fr  = bnd && (k / P >= 2);
      bz  = k < B * P;
      if (bnd) cref = ~cref;
      chk(adc_conv == cref, req, "adc_conv", int'(adc_conv), int'(cref));
      chk(frame_rdy == fr, req, "frame_rdy", int'(frame_rdy), int'(fr));
      chk(busy == bz, req, "busy", int'(busy), int'(bz));
      if (bz) chk(adc_range == rng, "R8", "adc_range held", int'(adc_range), int'(rng));
    end
    cmd_stop = 0; cmd_single = 0;
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1", "busy", int'(busy), 0);
    chk(adc_conv == 0, "R1", "adc_conv", int'(adc_conv), 0);
    chk(frame_rdy == 0, "R1", "frame_rdy", int'(frame_rdy), 0);
    chk(adc_range == 0, "R1", "adc_range", int'(adc_range), 0);
  endtask

  task automatic t_idle_stop();
    logic c0;
    @(negedge clk);
    c0 = adc_conv;
    cmd_stop = 1;
    @(negedge clk);
    cmd_stop = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(busy == 0, "R9", "busy after idle stop", int'(busy), 0);
      chk(adc_conv == c0, "R10", "conv idle", int'(adc_conv), int'(c0));
    end
    // R9: next single run must still reach its frame at the second boundary
    run_seq(0, 4, 2'd1, 5, 2, 0, 0, 14, 0, "R9");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    // R3 R5 R6: single run, count 5 -> period 6
    run_seq(0, 5, 2'd2, 6, 2, 0, 0, 20, 0, "R6");
    // R7 R8: continuous, count 3, stop sampled at edge 9 -> ends at 12; cfg change and extra start ignored
    run_seq(1, 3, 2'd3, 4, 3, 9, 5, 25, 1, "R7");
    // R4: count below min clamps to 3
    run_seq(0, 1, 2'd0, 4, 2, 0, 0, 12, 0, "R4");
    // R4: count above max clamps to 40
    run_seq(0, 100, 2'd1, 41, 2, 0, 0, 90, 0, "R4");
    // R7: stop sampled exactly on first boundary -> ends there with no frame
    run_seq(1, 5, 2'd2, 6, 1, 6, 0, 14, 0, "R7");
    // R3: continuous, several frames before stop at edge 20 -> ends at 20
    run_seq(1, 4, 2'd0, 5, 4, 20, 0, 28, 0, "R3");
    t_idle_stop();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule